// File: doc/BRIEF.md
# Core power-up sequencer

This block brings a single processor core's power domain from fully off to running. It drives two control-word images that sit next to the core's power logic: an 8-bit power control word and a 32-bit power-gate control word. After reset both words hold the core clamped and in reset, with the head-switch ramp disabled.

A one-cycle start request begins a fixed series of steps. The head-switch ramp is enabled first. The memory clamp is then released and the memory head switch is closed. Next the domain clamp is released, then both resets are released, and last the powered-up flag is raised. Three of the steps are followed by a settling wait of `SETTLE_US` microseconds, which comes to `SETTLE_US*CLK_MHZ` clock cycles. One down-counter times all three waits. The block reports completion with a one-cycle pulse. After that both words keep their final values until reset, and further start requests have no effect.

Top module: `core_pwrup_seq`

## Requirements
- R1: During and after synchronous reset, `pwr_word` is 0x33, `gate_word` is 0, `busy` is 0 and `done` is 0.
- R2: A start request sampled while idle sets `busy` at that edge. `pwr_word` is then 0x33, meaning bit 0 (domain clamp), bit 1 (memory clamp), bit 4 (core reset) and bit 5 (power-on reset) are high and all other bits are low.
- R3: One cycle after the start edge, `gate_word` becomes 0x1000_0001: bit 0 enables the head-switch ramp and bits 31:24 hold `RAMP_CNT` (16). It holds that value from then on.
- R4: After the first settling wait, only bit 1 (memory clamp) of `pwr_word` clears, giving 0x31.
- R5: One cycle later, bit 3 (memory head switch) sets, giving 0x39, and the second settling wait starts.
- R6: After the second wait, only bit 0 (domain clamp) clears, giving 0x38, and the third wait starts.
- R7: After the third wait, bits 4 and 5 clear on the same edge, giving 0x08. One cycle later bit 7 (powered-up flag) sets, giving 0x88.
- R8: Bit 2 (L1 reset disable) and bit 6 (clock gate) of `pwr_word` are never high.
- R9: A start request has no effect while `busy` is high or after the sequence has completed. Both words hold their final values until reset.
- R10: `done` is high for exactly one cycle, on the edge after the powered-up flag sets. `busy` falls on that same edge.
- R11: Each settling wait lasts `SETTLE_US*CLK_MHZ` cycles, which is 400 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin the power-up sequence |
| pwr_word | output | 8 | Power control word image |
| gate_word | output | 32 | Power-gate control word image |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hard to reach from the ports. One is a start request that lands exactly on a step boundary, such as the edge where a wait counter expires. The other is a reset that arrives deep inside one of the 400-cycle waits. The stimulus holds start high for an entire run on one pass and scatters random start pulses across every other run, so that some requests coincide with wait expiry. It also cuts one run short with a reset at a random cycle inside the sequence, then restarts and completes the sequence from the clean reset state.

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq #(
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_US = 2,
  parameter int RAMP_CNT  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic [7:0]  pwr_word,
  output logic [31:0] gate_word,
  output logic        busy,
  output logic        done
);

  localparam int WAIT_CYC = SETTLE_US * CLK_MHZ;
  localparam int CW       = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;

  localparam int B_DCLAMP = 0;
  localparam int B_MCLAMP = 1;
  localparam int B_MEMHS  = 3;
  localparam int B_CRST   = 4;
  localparam int B_PORST  = 5;
  localparam int B_UP     = 7;

  localparam logic [7:0]  PWR_INIT = 8'h33;
  localparam logic [31:0] GATE_ON  = {RAMP_CNT[7:0], 23'd0, 1'b1};
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CYC - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLAMP, ST_W1, ST_HS, ST_W2, ST_W3, ST_UP, ST_LAST, ST_HOLD
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign busy     = (st != ST_IDLE) && (st != ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      pwr_word  <= PWR_INIT;
      gate_word <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          pwr_word <= PWR_INIT;
          st       <= ST_CLAMP;
        end
        ST_CLAMP: begin
          gate_word <= GATE_ON;
          cnt       <= CNT_LOAD;
          st        <= ST_W1;
        end
        ST_W1: if (cnt_zero) begin
          pwr_word[B_MCLAMP] <= 1'b0;
          st                 <= ST_HS;
        end else cnt <= cnt - 1'b1;
        ST_HS: begin
          pwr_word[B_MEMHS] <= 1'b1;
          cnt               <= CNT_LOAD;
          st                <= ST_W2;
        end
        ST_W2: if (cnt_zero) begin
          pwr_word[B_DCLAMP] <= 1'b0;
          cnt                <= CNT_LOAD;
          st                 <= ST_W3;
        end else cnt <= cnt - 1'b1;
        ST_W3: if (cnt_zero) begin
          pwr_word[B_CRST]  <= 1'b0;
          pwr_word[B_PORST] <= 1'b0;
          st                <= ST_UP;
        end else cnt <= cnt - 1'b1;
        ST_UP: begin
          pwr_word[B_UP] <= 1'b1;
          st             <= ST_LAST;
        end
        ST_LAST: begin
          done <= 1'b1;
          st   <= ST_HOLD;
        end
        default: st <= ST_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/core_pwrup_seq_chk.sv
module core_pwrup_seq_chk #(
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_US = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  pwr_word,
  input logic [31:0] gate_word,
  input logic        busy,
  input logic        done
);
  localparam int WAIT_CYC = SETTLE_US * CLK_MHZ;

  logic [15:0] gap;
  logic        g0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      g0_q <= 1'b0;
    end else begin
      g0_q <= gate_word[0];
      if (gate_word[0] && !g0_q) gap <= 16'd1;
      else if (gap != 16'hFFFF) gap <= gap + 1'b1;
    end
  end

  assert_lowbits_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_word[2] == 1'b0) && (pwr_word[6] == 1'b0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_flag_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (pwr_word[7] && !busy));

  assert_resets_pair_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_word[4] == pwr_word[5]);

  assert_gate_value_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_word == 32'h0) || (gate_word == 32'h1000_0001));

  assert_final_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && gate_word[0]) |=> ($stable(pwr_word) && $stable(gate_word) && !busy));

  assert_wait_len_R11: assert property (@(posedge clk) disable iff (rst)
    (g0_q && $fell(pwr_word[1])) |-> (gap == 16'(WAIT_CYC)));

endmodule

bind core_pwrup_seq core_pwrup_seq_chk #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) i_chk (
  .clk(clk), .rst(rst), .start(start), .pwr_word(pwr_word),
  .gate_word(gate_word), .busy(busy), .done(done)
);

// File: tb/test_core_pwrup_seq.sv
module test_core_pwrup_seq;
  localparam int W    = 2 * 200;
  localparam int KFIN = 4 + 3 * W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  pwr_word;
  logic [31:0] gate_word;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;
  int k      = -1;
  int cyc    = 0;
  int seed   = 7;

  always #2.5 clk = ~clk;

  core_pwrup_seq i_core_pwrup_seq (
    .clk(clk), .rst(rst), .start(start), .pwr_word(pwr_word),
    .gate_word(gate_word), .busy(busy), .done(done)
  );

  function automatic logic [7:0] exp_pwr(int kk);
    if (kk < 1 + W)     return 8'h33;
    if (kk < 2 + W)     return 8'h31;
    if (kk < 2 + 2 * W) return 8'h39;
    if (kk < 2 + 3 * W) return 8'h38;
    if (kk < 3 + 3 * W) return 8'h08;
    return 8'h88;
  endfunction

  function automatic logic [31:0] exp_gate(int kk);
    return (kk >= 1) ? 32'h1000_0001 : 32'h0;
  endfunction

  function automatic string tag_of(int kk);
    if (kk < 0)          return "R1";
    if (kk < 1)          return "R2";
    if (kk < 1 + W)      return "R3/R11";
    if (kk < 2 + W)      return "R4";
    if (kk < 2 + 2 * W)  return "R5/R11";
    if (kk < 2 + 3 * W)  return "R6/R11";
    if (kk < KFIN)       return "R7";
    if (kk == KFIN)      return "R10";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d k=%0d actual=%h expected=%h", tag, cyc, k, act, exp);
    end
  endtask

  task automatic step(logic r, logic s);
    @(negedge clk);
    rst = r;
    start = s;
    @(posedge clk);
    cyc++;
    if (r) k = -1;
    else if (k < 0 && s) k = 0;
    else if (k >= 0 && k <= KFIN) k++;
    #1;
    chk(tag_of(k), {24'd0, pwr_word}, {24'd0, (k < 0) ? 8'h33 : exp_pwr(k)});
    chk(tag_of(k), gate_word, (k < 0) ? 32'h0 : exp_gate(k));
    chk(tag_of(k) == "R9" ? "R9" : "R10", {31'd0, busy}, {31'd0, (k >= 0 && k < KFIN)});
    chk("R10", {31'd0, done}, {31'd0, (k == KFIN)});
    chk("R8", {30'd0, pwr_word[6], pwr_word[2]}, 32'd0);
  endtask

  initial begin
    while (cyc < 200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end in time");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) step(1'b1, 1'b0);   // R1 reset values
    for (int run = 0; run < 10; run++) begin
      int cut;
      int idle;
      cut  = (run == 4) ? 1 + int'($urandom_range(3 * W, 2)) : -1;
      idle = int'($urandom_range(5, 0));
      for (int i = 0; i < idle; i++) step(1'b0, 1'b0);   // R1 idle holds
      step(1'b0, 1'b1);                                  // R2 accepted start
      while (k <= KFIN && k != cut) begin
        logic s;
        if (run == 1)      s = 1'b1;                     // R9 start held high
        else if (run == 0) s = 1'b0;
        else               s = ($urandom_range(7, 0) == 0);
        step(1'b0, s);
      end
      for (int i = 0; i < 6; i++) step(1'b0, (run != 0) && (i % 2 == 0));  // R9 hold after done
      step(1'b1, 1'b1);                                  // R1 reset beats start
      step(1'b1, 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule